// File: doc/BRIEF.md
# Bus Master Cycle Sequencer with Retry

This block sequences the memory cycles that a network controller's DMA engine runs on a shared system bus. When a transfer is queued it raises a bus request and waits for the grant, then runs a cycle with one address phase followed by one or more data phases. A ready input from the addressed memory can stretch the data phase. The block drives the early cycle start, address strobe, direction and data strobe lines. These lines are modelled as tri-state through a single output enable, which is high only while the block owns the bus.

A retry input lets the system abort a cycle that has a correctable error. In replay mode the aborted cycle is run again as soon as retry is released, with the same direction. In halt mode the abort also sets a sticky retry flag. The block then releases the bus, and it starts no cycle, including the replay, until software clears the flag. A second configuration bit chooses between sampling the ready input directly or passing it through a synchronizer first.

Top module: `bmc_seq`

## Requirements
- R1: The bus request `hold_o` rises one cycle after a transfer is queued while idle. The first address phase (`as_n_o` low) starts on the clock edge after `hlda_i` is sampled high, never before.
- R2: `ecs_n_o` goes low at the rising clock edge that starts the address phase and returns high at the following falling edge.
- R3: `as_n_o` is low for exactly one cycle per address phase. `ds_n_o` is low during every data-phase cycle, and the two are never low together.
- R4: While the strobes are enabled, `dir_o` is 0 for a read and 1 for a write.
- R5: With `cfg_async_rdy`=0, every cycle in which `rdy_n_i` is sampled high adds one wait state. Sampling it low ends the data phase, so a cycle has `ds_n_o` low for (waits+1) cycles and `xfer_done_o` pulses for one cycle right after.
- R6: With `cfg_async_rdy`=1, `rdy_n_i` passes through a SYNC_STAGES-deep synchronizer. The data phase lasts SYNC_STAGES cycles longer than in R5, which is (waits+3) with the default of 2.
- R7: `retry_i` sampled high in an address or data phase ends the cycle at that edge with no done pulse. The strobes go inactive while `hold_o` stays high. With `cfg_retry_halt`=0, the same cycle is replayed once retry falls, with the original direction whatever `xfer_write_i` shows then.
- R8: With `cfg_retry_halt`=1, an abort sets `retry_flag_o`. After retry falls the bus is released (`hold_o` low) and no cycle starts until a `retry_clr_i` pulse clears the flag. The aborted cycle is then requested again and replayed.
- R9: If an abort and `retry_clr_i` fall in the same cycle, the flag ends up set.
- R10: After reset, and whenever the bus is not owned, `strb_oe_o` is 0, all strobes are high and `dir_o` is 0.
- R11: A transfer completing with `xfer_last_i`=0 keeps `hold_o` high, and the next address phase follows after a single gap cycle. A transfer completing with `xfer_last_i`=1 drops `hold_o` in the cycle after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_async_rdy | input | 1 | 1: synchronize ready before use |
| cfg_retry_halt | input | 1 | 1: retry freezes DMA until flag cleared |
| xfer_req_i | input | 1 | A transfer is queued |
| xfer_write_i | input | 1 | Direction of queued transfer (1 write) |
| xfer_last_i | input | 1 | Queued transfer is the last of the burst |
| xfer_done_o | output | 1 | One-cycle pulse when a cycle completes |
| hold_o | output | 1 | Bus request |
| hlda_i | input | 1 | Bus grant |
| ecs_n_o | output | 1 | Early cycle start, active low |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| dir_o | output | 1 | Transfer direction (1 write) |
| strb_oe_o | output | 1 | Output enable of the strobe drivers |
| rdy_n_i | input | 1 | Ready, high inserts a wait state |
| retry_i | input | 1 | Bus retry |
| retry_flag_o | output | 1 | Sticky retry status |
| retry_clr_i | input | 1 | Software clear of the retry flag |

## Verification
Two events can collide in one cycle. The first is a retry abort on the same edge where a low ready would end the data phase. The retry tests hold `rdy_n_i` low throughout, so every abort meets a terminating ready, and the bench expects no done pulse, one extra address phase and only one done per transfer. The second is a halt-mode abort on the edge where software clears the flag. The bench raises `retry_i` and `retry_clr_i` together in the first data-phase cycle, checks that `retry_flag_o` stays set and `hold_o` falls, and only then clears the flag to let the replay finish.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_T1,
    ST_T2,
    ST_RHOLD,
    ST_SUSP
  } bmc_state_e;

  function automatic logic owns_bus(bmc_state_e s);
    return (s == ST_T1) || (s == ST_T2) || (s == ST_RHOLD);
  endfunction

  function automatic logic wants_bus(bmc_state_e s);
    return owns_bus(s) || (s == ST_REQ);
  endfunction

endpackage

// File: rtl/bmc_rdy_sync.sv
module bmc_rdy_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_en,
  input  logic rdy_n_raw,
  output logic rdy_n_eff
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] chain_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= rdy_n_raw;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[MSB-1:0], rdy_n_raw};
      end
    end
  endgenerate

  assign rdy_n_eff = async_en ? chain_q[MSB] : rdy_n_raw;

endmodule

// File: rtl/bmc_fsm.sv
module bmc_fsm
  import bmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_halt,
  input  logic       xfer_req_i,
  input  logic       xfer_write_i,
  input  logic       xfer_last_i,
  input  logic       hlda_i,
  input  logic       rdy_n_eff,
  input  logic       retry_i,
  input  logic       retry_clr_i,
  output bmc_state_e st_q,
  output bmc_state_e st_d,
  output logic       dir_d,
  output logic       done_o,
  output logic       flag_o
);
  logic dir_q, last_q, replay_q, flag_q, done_q;
  logic fin, abort, take;

  always_comb begin
    st_d  = st_q;
    fin   = 1'b0;
    abort = 1'b0;
    case (st_q)
      ST_IDLE:  if (xfer_req_i && !flag_q) st_d = ST_REQ;
      ST_REQ:   if (hlda_i && (xfer_req_i || replay_q)) st_d = ST_T1;
      ST_T1: begin
        if (retry_i) begin
          st_d  = ST_RHOLD;
          abort = 1'b1;
        end else begin
          st_d = ST_T2;
        end
      end
      ST_T2: begin
        if (retry_i) begin
          st_d  = ST_RHOLD;
          abort = 1'b1;
        end else if (!rdy_n_eff) begin
          fin  = 1'b1;
          st_d = last_q ? ST_IDLE : ST_REQ;
        end
      end
      ST_RHOLD: if (!retry_i) st_d = flag_q ? ST_SUSP : ST_T1;
      ST_SUSP:  if (!flag_q) st_d = ST_REQ;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign take  = (st_q == ST_REQ) && (st_d == ST_T1) && !replay_q;
  assign dir_d = take ? xfer_write_i : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      dir_q    <= 1'b0;
      last_q   <= 1'b1;
      replay_q <= 1'b0;
      flag_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      flag_q <= (abort && cfg_halt) || (flag_q && !retry_clr_i);
      if (abort)              replay_q <= 1'b1;
      else if (st_d == ST_T1) replay_q <= 1'b0;
      if (take) begin
        dir_q  <= xfer_write_i;
        last_q <= xfer_last_i;
      end
    end
  end

  assign done_o = done_q;
  assign flag_o = flag_q;

  assert_grant_first_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REQ && !hlda_i) |=> (st_q != ST_T1));

  assert_ready_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T2 && !retry_i && !rdy_n_eff) |=> (done_o && st_q != ST_T2));

  assert_retry_aborts_R7: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_T1 || st_q == ST_T2) && retry_i) |=> (st_q == ST_RHOLD && !done_o));

  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_T1 || st_q == ST_T2) && retry_i && cfg_halt) |=> flag_o);

  assert_flag_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> (st_q == ST_RHOLD || st_q == ST_SUSP));

endmodule

// File: rtl/bmc_strobe.sv
module bmc_strobe
  import bmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bmc_state_e st_d,
  input  logic       dir_d,
  output logic       hold_o,
  output logic       oe_o,
  output logic       as_n_o,
  output logic       ds_n_o,
  output logic       dir_o,
  output logic       ecs_n_o
);
  logic arm_q, half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o <= 1'b0;
      oe_o   <= 1'b0;
      as_n_o <= 1'b1;
      ds_n_o <= 1'b1;
      dir_o  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      hold_o <= wants_bus(st_d);
      oe_o   <= owns_bus(st_d);
      as_n_o <= (st_d != ST_T1);
      ds_n_o <= (st_d != ST_T2);
      dir_o  <= owns_bus(st_d) && dir_d;
      arm_q  <= (st_d == ST_T1);
    end
  end

  // second half of the address phase: captured on the falling edge
  always_ff @(negedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= arm_q;
  end

  assign ecs_n_o = !(arm_q && !half_q);

  assert_as_single_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n_o) |=> as_n_o);

  assert_as_ds_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !((!as_n_o) && (!ds_n_o)));

  assert_released_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> (as_n_o && ds_n_o && ecs_n_o && !dir_o));

endmodule

// File: rtl/bmc_seq.sv
module bmc_seq
  import bmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_async_rdy,
  input  logic cfg_retry_halt,
  input  logic xfer_req_i,
  input  logic xfer_write_i,
  input  logic xfer_last_i,
  output logic xfer_done_o,
  output logic hold_o,
  input  logic hlda_i,
  output logic ecs_n_o,
  output logic as_n_o,
  output logic ds_n_o,
  output logic dir_o,
  output logic strb_oe_o,
  input  logic rdy_n_i,
  input  logic retry_i,
  output logic retry_flag_o,
  input  logic retry_clr_i
);
  bmc_state_e st_q, st_d;
  logic       rdy_n_eff, dir_d;

  bmc_rdy_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_en  (cfg_async_rdy),
    .rdy_n_raw (rdy_n_i),
    .rdy_n_eff (rdy_n_eff)
  );

  bmc_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cfg_halt     (cfg_retry_halt),
    .xfer_req_i   (xfer_req_i),
    .xfer_write_i (xfer_write_i),
    .xfer_last_i  (xfer_last_i),
    .hlda_i       (hlda_i),
    .rdy_n_eff    (rdy_n_eff),
    .retry_i      (retry_i),
    .retry_clr_i  (retry_clr_i),
    .st_q         (st_q),
    .st_d         (st_d),
    .dir_d        (dir_d),
    .done_o       (xfer_done_o),
    .flag_o       (retry_flag_o)
  );

  bmc_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .st_d    (st_d),
    .dir_d   (dir_d),
    .hold_o  (hold_o),
    .oe_o    (strb_oe_o),
    .as_n_o  (as_n_o),
    .ds_n_o  (ds_n_o),
    .dir_o   (dir_o),
    .ecs_n_o (ecs_n_o)
  );

  assert_enable_needs_request_R1: assert property (@(posedge clk) disable iff (rst)
    strb_oe_o |-> hold_o);

  assert_no_done_while_held_R8: assert property (@(posedge clk) disable iff (rst)
    retry_flag_o |-> (!xfer_done_o && as_n_o));

endmodule

// File: tb/bmc_seq_tb_top.sv
module bmc_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_async_rdy = 1'b0, cfg_retry_halt = 1'b0;
  logic xfer_req = 1'b0, xfer_write = 1'b0, xfer_last = 1'b1;
  logic hlda = 1'b0, rdy_n = 1'b1, retry = 1'b0, retry_clr = 1'b0;
  logic done, hold, ecs_n, as_n, ds_n, dir, oe, flag;

  int total = 0, fails = 0;
  int as_cnt, ds_cnt, done_cnt, step_idx, t1_at;
  logic exp_dir;
  bit finished = 0;

  always #5 clk = ~clk;

  bmc_seq dut_i (
    .clk(clk), .rst(rst), .cfg_async_rdy(cfg_async_rdy), .cfg_retry_halt(cfg_retry_halt),
    .xfer_req_i(xfer_req), .xfer_write_i(xfer_write), .xfer_last_i(xfer_last),
    .xfer_done_o(done), .hold_o(hold), .hlda_i(hlda), .ecs_n_o(ecs_n), .as_n_o(as_n),
    .ds_n_o(ds_n), .dir_o(dir), .strb_oe_o(oe), .rdy_n_i(rdy_n), .retry_i(retry),
    .retry_flag_o(flag), .retry_clr_i(retry_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_counts();
    as_cnt = 0; ds_cnt = 0; done_cnt = 0; step_idx = 0; t1_at = -1;
  endtask

  // one clock, sampled 2 ns after the rising edge
  task automatic step();
    @(posedge clk); #2;
    step_idx++;
    if (!as_n) begin
      as_cnt++;
      if (t1_at < 0) t1_at = step_idx;
      check(dir == exp_dir, "R4 dir in address phase", dir, exp_dir);
    end
    if (!ds_n) ds_cnt++;
    if (done) done_cnt++;
  endtask

  task automatic run_to_done();
    for (int i = 0; i < 60 && done_cnt == 0; i++) step();
  endtask

  task automatic run_xfer(input logic wr, input logic last, input int waits);
    bit ecs_seen = 0;
    clear_counts();
    xfer_req = 1; xfer_write = wr; xfer_last = last; exp_dir = wr; rdy_n = 1;
    for (int i = 0; i < 60 && done_cnt == 0; i++) begin
      step();
      if (!as_n && !ecs_seen) begin
        ecs_seen = 1;
        check(ecs_n == 1'b0, "R2 ecs low after rising edge", ecs_n, 0);
        @(negedge clk); #2;
        check(ecs_n == 1'b1, "R2 ecs high after falling edge", ecs_n, 1);
      end
      if (!ds_n && ds_cnt == waits + 1) rdy_n = 0;
    end
    if (last) xfer_req = 0;
    rdy_n = 1;
  endtask

  task automatic t_reset();
    check(oe == 0, "R10 reset oe", oe, 0);
    check(hold == 0, "R10 reset hold", hold, 0);
    check({as_n, ds_n, ecs_n} == 3'b111, "R10 reset strobes", {as_n, ds_n, ecs_n}, 7);
    check(dir == 0 && flag == 0 && done == 0, "R10 reset dir/flag/done", {dir, flag, done}, 0);
  endtask

  task automatic t_grant();
    clear_counts();
    hlda = 0; xfer_req = 1; xfer_write = 0; xfer_last = 1; exp_dir = 0; rdy_n = 0;
    repeat (4) step();
    check(hold == 1, "R1 hold raised while waiting", hold, 1);
    check(as_cnt == 0, "R1 no address phase without grant", as_cnt, 0);
    check(oe == 0, "R10 strobes off before grant", oe, 0);
    hlda = 1;
    step();
    check(as_n == 0, "R1 address phase one edge after grant", as_n, 0);
    run_to_done();
    xfer_req = 0; rdy_n = 1;
    check(done_cnt == 1, "R1 granted transfer completes", done_cnt, 1);
    check(hold == 0, "R11 last transfer drops hold", hold, 0);
  endtask

  task automatic t_sync_waits();
    cfg_async_rdy = 0;
    run_xfer(0, 1, 0);
    check(t1_at == 2, "R1 idle to address phase latency", t1_at, 2);
    check(as_cnt == 1, "R3 one address cycle", as_cnt, 1);
    check(ds_cnt == 1, "R5 zero waits", ds_cnt, 1);
    check(done_cnt == 1, "R5 single done pulse", done_cnt, 1);
    step();
    check(done == 0 && oe == 0, "R10 released after last", {done, oe}, 0);
    run_xfer(1, 1, 3);
    check(ds_cnt == 4, "R5 three waits", ds_cnt, 4);
    check(as_cnt == 1, "R3 one address cycle with waits", as_cnt, 1);
  endtask

  task automatic t_async_waits();
    cfg_async_rdy = 1;
    step(); step();
    run_xfer(0, 1, 0);
    check(ds_cnt == 3, "R6 synchronized zero waits", ds_cnt, 3);
    step(); step();
    run_xfer(1, 1, 2);
    check(ds_cnt == 5, "R6 synchronized two waits", ds_cnt, 5);
    cfg_async_rdy = 0;
    step(); step();
  endtask

  task automatic t_back_to_back();
    run_xfer(0, 0, 0);
    check(hold == 1, "R11 hold kept between transfers", hold, 1);
    run_xfer(1, 1, 1);
    check(t1_at == 1, "R11 one gap cycle", t1_at, 1);
    check(ds_cnt == 2, "R5 second transfer one wait", ds_cnt, 2);
    check(hold == 0, "R11 hold dropped after last", hold, 0);
  endtask

  task automatic start_and_reach_data(input logic wr);
    clear_counts();
    xfer_req = 1; xfer_write = wr; xfer_last = 1; exp_dir = wr; rdy_n = 0;
    for (int i = 0; i < 20 && ds_n; i++) step();
  endtask

  task automatic t_retry_replay();
    cfg_retry_halt = 0;
    start_and_reach_data(1);
    retry = 1; xfer_write = 0;
    step();
    check(as_n && ds_n, "R7 strobes inactive after abort", {as_n, ds_n}, 3);
    check(hold == 1 && oe == 1, "R7 bus kept during retry", {hold, oe}, 3);
    check(done_cnt == 0, "R7 no done on abort", done_cnt, 0);
    step(); step();
    check(flag == 0, "R7 no flag in replay mode", flag, 0);
    retry = 0;
    run_to_done();
    xfer_req = 0;
    check(as_cnt == 2, "R7 cycle replayed", as_cnt, 2);
    check(done_cnt == 1, "R7 one done for replayed cycle", done_cnt, 1);
  endtask

  task automatic t_retry_halt(input bit collide);
    int as_before;
    cfg_retry_halt = 1;
    start_and_reach_data(0);
    retry = 1; xfer_write = 1;
    if (collide) retry_clr = 1;
    step();
    retry_clr = 0;
    if (collide) check(flag == 1, "R9 set beats clear", flag, 1);
    else         check(flag == 1, "R8 flag set on abort", flag, 1);
    step();
    retry = 0;
    step();
    check(hold == 0 && oe == 0, "R8 bus released while flagged", {hold, oe}, 0);
    as_before = as_cnt;
    repeat (4) step();
    check(as_cnt == as_before, "R8 no cycle while flagged", as_cnt, as_before);
    check(hold == 0 && flag == 1, "R8 stays suspended", {hold, flag}, 1);
    retry_clr = 1;
    step();
    retry_clr = 0;
    check(flag == 0, "R8 flag cleared by software", flag, 0);
    run_to_done();
    xfer_req = 0;
    check(as_cnt == 2, "R8 replay after clear", as_cnt, 2);
    check(done_cnt == 1, "R8 replayed cycle completes", done_cnt, 1);
    cfg_retry_halt = 0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    exp_dir = 0;
    clear_counts();
    repeat (3) @(posedge clk);
    #2 rst = 0;
    t_reset();
    t_grant();
    step();
    t_sync_waits();
    step();
    t_async_waits();
    t_back_to_back();
    step();
    t_retry_replay();
    step();
    t_retry_halt(0);
    step();
    t_retry_halt(1);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule